// File: doc/BRIEF.md
# Vertical 3-to-5 Line Scaler

This block stretches a television-rate picture to fit a panel with more lines. Every three source lines become five panel lines. In the normal mode each panel pixel is a four-term weighted sum of up to two neighbouring source lines, rounded up by one. A fallback mode repeats source lines one, two and two times, with no blending. The source is 8-bit colour: two bits of blue, three of green and three of red. The panel receives 15-bit colour with a five-bit sum for each channel.

The source writes pixels at its own pace, with a start-of-frame marker on the first pixel of the first visible line. Lines are stored in a ring of four line memories. When the third line of a group is complete, a ready flag starts the panel-side sequencer. The sequencer emits five line slots, each with data enable and horizontal sync. After the last group it adds padding lines if any slots were skipped, then the vertical sync lines. An optional skip mode leaves every sixth panel line slot silent. The same number of horizontal sync pulses is then added before vertical sync, so the panel still sees a complete frame.

Top module: `vscale_3to5`

## Requirements
- R1: The input pixel has red in bits [2:0], green in bits [5:3] and blue in bits [7:6]. The output has the red sum in bits [4:0], the green sum in [9:5] and the blue sum in [14:10]. The output is zero whenever out_de is low.
- R2: In blend mode, with source lines s0, s1, s2 of a group, the five output lines are, per channel: 4·s0+1, 3·s0+s1+1, 4·s1+1, 2·s1+2·s2+1 and 4·s2+1. Every enabled channel sum is therefore at least 1.
- R3: With mode_blend low, the five output lines are 4·s0+1, 4·s1+1, 4·s1+1, 4·s2+1 and 4·s2+1 per channel.
- R4: A group is not shown until its third source line has been fully written. The next group's lines may be written into the fourth ring slot while the current group is being shown.
- R5: Each output line slot lasts LINE_PIX+H_BLANK clocks. out_de is high for LINE_PIX consecutive clocks and is constant within a line for constant-colour input. out_hs is high for HS_W clocks and never together with out_de.
- R6: A frame of SRC_LINES source lines gives SRC_LINES·5/3 output lines with out_de. These are followed by VS_LINES lines with out_vs high, each carrying one horizontal sync pulse. out_de is never high together with out_vs.
- R7: With skip_en high, each output slot whose frame-relative index modulo 6 equals 5 carries neither out_de nor out_hs. The skipped slots are made up by the same number of hsync-only lines before vertical sync, so the frame has SRC_LINES·5/3+VS_LINES hsync pulses in either mode.
- R8: While rst_n is low, and on the clock after it, out_de, out_hs and out_vs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the source and panel sides |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | A source pixel is present this cycle |
| src_sof | input | 1 | Marks the first pixel of the first visible source line |
| src_pix | input | 8 | Source pixel, blue/green/red packed |
| mode_blend | input | 1 | 1 selects four-term blending, 0 selects 1-2-2 line repeat |
| skip_en | input | 1 | Leaves every sixth output slot silent and pads hsync later |
| out_pix | output | 15 | Output colour, five bits per channel |
| out_de | output | 1 | Output data enable |
| out_hs | output | 1 | Output horizontal sync |
| out_vs | output | 1 | Output vertical sync |

## Verification
Some properties are checked on every cycle: data enable and horizontal sync never overlap, vertical sync never coincides with enabled pixels, and the enable and sync pulse widths are exact. Every enabled pixel must also show the +1 rounding in each channel, and the pixel bus is zero outside data enable. The blend weights, the 1-2-2 repeat order and the wait for the third source line depend on the source colours, so only the bench's frames with known per-line colours can show them. The same holds for the slot that skip mode omits and for the padding pulses.

// File: rtl/vs_pkg.sv
// Package: shared types and the blend-tap selection for the 3:5 scaler.
// Assumes a group is always three source lines and five output lines.
package vs_pkg;

    typedef logic [7:0]  src_pix_t;
    typedef logic [14:0] out_pix_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ACTIVE,
        SQ_PAD,
        SQ_VSYNC
    } seq_state_t;

    // For output line j (0..4) of a group and operand tap (0..3), return
    // which source line of the group (0, 1 or 2) feeds that operand.
    function automatic logic [1:0] tap_src(input logic blend,
                                           input logic [2:0] j,
                                           input logic [1:0] tap);
        logic [1:0] r;
        if (blend) begin
            case (j)
                3'd0:    r = 2'd0;
                3'd1:    r = (tap == 2'd3) ? 2'd1 : 2'd0;
                3'd2:    r = 2'd1;
                3'd3:    r = (tap >= 2'd2) ? 2'd2 : 2'd1;
                default: r = 2'd2;
            endcase
        end else begin
            case (j)
                3'd0:       r = 2'd0;
                3'd1, 3'd2: r = 2'd1;
                default:    r = 2'd2;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/vs_linemem.sv
// Module: one source line memory with one write port and one registered
// read port. Contents are not reset; reads return what was last written.
module vs_linemem #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Write on request and read every cycle with one clock of latency.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/vs_srcwr.sv
// Module: source-side writer. It counts columns and lines, places each line
// in the next slot of the four-slot ring and pulses grp_rdy after the third
// line of each group. It assumes src_sof comes with src_valid on the first
// pixel of a frame.
module vs_srcwr #(
    parameter int LINE_PIX = 256,
    localparam int AW      = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  logic          src_sof,
    output logic          wr_en,
    output logic [1:0]    wr_slot,
    output logic [AW-1:0] wr_col,
    output logic          grp_rdy,
    output logic [1:0]    grp_base
);

    logic [AW-1:0] col;
    logic [1:0]    slot;
    logic [1:0]    lig;
    logic [AW-1:0] eff_col;
    logic [1:0]    eff_slot;
    logic [1:0]    eff_lig;

    // Start of frame restarts the column, slot and line-in-group counts.
    always_comb begin
        eff_col  = src_sof ? '0 : col;
        eff_slot = src_sof ? 2'd0 : slot;
        eff_lig  = src_sof ? 2'd0 : lig;
        wr_en    = src_valid;
        wr_slot  = eff_slot;
        wr_col   = eff_col;
    end

    // Advance the counters and flag each completed group of three lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col      <= '0;
            slot     <= 2'd0;
            lig      <= 2'd0;
            grp_rdy  <= 1'b0;
            grp_base <= 2'd0;
        end else begin
            grp_rdy <= 1'b0;
            if (src_valid) begin
                if (eff_col == AW'(LINE_PIX - 1)) begin
                    col  <= '0;
                    slot <= eff_slot + 2'd1;
                    if (eff_lig == 2'd2) begin
                        lig      <= 2'd0;
                        grp_rdy  <= 1'b1;
                        grp_base <= eff_slot - 2'd2;
                    end else begin
                        lig <= eff_lig + 2'd1;
                    end
                end else begin
                    col  <= eff_col + AW'(1);
                    slot <= eff_slot;
                    lig  <= eff_lig;
                end
            end
        end
    end

endmodule

// File: rtl/vs_mix4.sv
// Module: three-stage adder for the four operands of one output pixel, per
// channel: a+b, then +c, then +d+1. The c and d operands are delayed inside
// so that they meet their stage. Latency is three clocks.
module vs_mix4
    import vs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_pix_t a,
    input  src_pix_t b,
    input  src_pix_t c,
    input  src_pix_t d,
    output out_pix_t mix
);

    src_pix_t c_q;
    src_pix_t d_q1;
    src_pix_t d_q2;

    // Delay c by one stage and d by two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q  <= '0;
            d_q1 <= '0;
            d_q2 <= '0;
        end else begin
            c_q  <= c;
            d_q1 <= d;
            d_q2 <= d_q1;
        end
    end

    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
        localparam int LO  = (ch == 0) ? 0 : (ch == 1) ? 3 : 6;
        localparam int W   = (ch == 2) ? 2 : 3;
        localparam int OLO = ch * 5;

        logic [4:0] s0;
        logic [4:0] s1;
        logic [4:0] s2;

        // Accumulate one channel over three stages with the +1 at the end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s0 <= '0;
                s1 <= '0;
                s2 <= '0;
            end else begin
                s0 <= 5'(a[LO +: W]) + 5'(b[LO +: W]);
                s1 <= s0 + 5'(c_q[LO +: W]);
                s2 <= s1 + 5'(d_q2[LO +: W]) + 5'd1;
            end
        end

        assign mix[OLO +: 5] = s2;
    end

endmodule

// File: rtl/vs_seq.sv
// Module: panel-side sequencer. It runs the horizontal counter, walks the
// five lines of each ready group, skips slots when asked, and then emits
// the padding and vertical sync lines. Outputs are raw, before the pipeline
// delay. It assumes at most one group waits while another is shown.
module vs_seq
    import vs_pkg::*;
#(
    parameter int LINE_PIX  = 256,
    parameter int H_BLANK   = 32,
    parameter int HS_W      = 8,
    parameter int GROUPS    = 96,
    parameter int VS_LINES  = 4,
    localparam int H_TOTAL  = LINE_PIX + H_BLANK,
    localparam int HCW      = $clog2(H_TOTAL + 1),
    localparam int AW       = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1,
    localparam int GCW      = $clog2(GROUPS + 1),
    localparam int SKW      = $clog2(GROUPS * 5 + 1),
    localparam int VCW      = $clog2(VS_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          grp_rdy,
    input  logic [1:0]    grp_base,
    input  logic          skip_en,
    output logic [AW-1:0] col,
    output logic [1:0]    base,
    output logic [2:0]    line_j,
    output logic          raw_de,
    output logic          raw_hs,
    output logic          raw_vs
);

    seq_state_t     state;
    logic [HCW-1:0] hcnt;
    logic [GCW-1:0] grp;
    logic [2:0]     m6;
    logic [SKW-1:0] skipped;
    logic [SKW-1:0] padn;
    logic [VCW-1:0] vsn;
    logic           pend;
    logic [1:0]     pbase;
    logic           line_end;
    logic           slot_skip;
    logic           last_grp;
    logic           take;
    logic           hs_win;

    // Decode the end of a line, a skipped slot and when a waiting group starts.
    always_comb begin
        line_end  = (hcnt == HCW'(H_TOTAL - 1));
        slot_skip = skip_en && (m6 == 3'd5) && (state == SQ_ACTIVE);
        last_grp  = (grp == GCW'(GROUPS - 1));
        take      = pend && ((state == SQ_IDLE) ||
                    ((state == SQ_ACTIVE) && line_end && (line_j == 3'd4) && !last_grp));
        hs_win    = (hcnt >= HCW'(LINE_PIX + 1)) && (hcnt < HCW'(LINE_PIX + 1 + HS_W));
    end

    // Remember one ready group until the sequencer can start it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            pbase <= 2'd0;
        end else begin
            if (grp_rdy) begin
                pend  <= 1'b1;
                pbase <= grp_base;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end

    // Horizontal counter, running whenever a line slot is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) hcnt <= '0;
        else if (state == SQ_IDLE) hcnt <= '0;
        else hcnt <= line_end ? '0 : hcnt + HCW'(1);
    end

    // Line and frame sequencing: group lines, padding, vertical sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            line_j  <= 3'd0;
            base    <= 2'd0;
            grp     <= '0;
            m6      <= 3'd0;
            skipped <= '0;
            padn    <= '0;
            vsn     <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (pend) begin
                        state  <= SQ_ACTIVE;
                        base   <= pbase;
                        line_j <= 3'd0;
                    end
                end
                SQ_ACTIVE: begin
                    if (line_end) begin
                        m6 <= (m6 == 3'd5) ? 3'd0 : m6 + 3'd1;
                        if (slot_skip) skipped <= skipped + SKW'(1);
                        if (line_j == 3'd4) begin
                            line_j <= 3'd0;
                            if (last_grp) begin
                                grp   <= '0;
                                padn  <= '0;
                                vsn   <= '0;
                                state <= ((skipped != '0) || slot_skip) ? SQ_PAD : SQ_VSYNC;
                            end else begin
                                grp <= grp + GCW'(1);
                                if (pend) base <= pbase;
                                else state <= SQ_IDLE;
                            end
                        end else begin
                            line_j <= line_j + 3'd1;
                        end
                    end
                end
                SQ_PAD: begin
                    if (line_end) begin
                        if (padn == skipped - SKW'(1)) state <= SQ_VSYNC;
                        else padn <= padn + SKW'(1);
                    end
                end
                default: begin
                    if (line_end) begin
                        if (vsn == VCW'(VS_LINES - 1)) begin
                            state   <= SQ_IDLE;
                            m6      <= 3'd0;
                            skipped <= '0;
                        end else begin
                            vsn <= vsn + VCW'(1);
                        end
                    end
                end
            endcase
        end
    end

    // Raw enables and syncs for the current slot, and the column to read.
    always_comb begin
        col    = AW'(hcnt);
        raw_de = (state == SQ_ACTIVE) && !slot_skip && (hcnt < HCW'(LINE_PIX));
        raw_hs = (state != SQ_IDLE) && !slot_skip && hs_win;
        raw_vs = (state == SQ_VSYNC);
    end

endmodule

// File: rtl/vscale_3to5.sv
// Module: top of the vertical 3-to-5 scaler. Source lines go into a ring of
// four line memories. The sequencer reads all four at the same column, and
// the group's three lines are routed to the four mixer operands. Enables and
// syncs are delayed to match the memory read plus the three mixer stages.
// Assumes one clock for both sides and at least 5/3 output line times per
// source line on average.
module vscale_3to5
    import vs_pkg::*;
#(
    parameter int LINE_PIX  = 256,
    parameter int H_BLANK   = 32,
    parameter int HS_W      = 8,
    parameter int SRC_LINES = 288,
    parameter int VS_LINES  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        src_valid,
    input  logic        src_sof,
    input  logic [7:0]  src_pix,
    input  logic        mode_blend,
    input  logic        skip_en,
    output logic [14:0] out_pix,
    output logic        out_de,
    output logic        out_hs,
    output logic        out_vs
);

    localparam int GROUPS = SRC_LINES / 3;
    localparam int SLOTS  = 4;
    localparam int PIPE   = 4;
    localparam int AW     = (LINE_PIX > 1) ? $clog2(LINE_PIX) : 1;

    logic          wr_en;
    logic [1:0]    wr_slot;
    logic [AW-1:0] wr_col;
    logic          grp_rdy;
    logic [1:0]    grp_base;
    logic [AW-1:0] rd_col;
    logic [1:0]    base;
    logic [2:0]    line_j;
    logic          raw_de;
    logic          raw_hs;
    logic          raw_vs;
    src_pix_t      rd [SLOTS];
    logic [1:0]    base_q;
    logic [2:0]    j_q;
    src_pix_t      op [4];
    out_pix_t      mix;
    logic [PIPE-1:0] de_d;
    logic [PIPE-1:0] hs_d;
    logic [PIPE-1:0] vs_d;

    vs_srcwr #(.LINE_PIX(LINE_PIX)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_valid(src_valid),
        .src_sof  (src_sof),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_col   (wr_col),
        .grp_rdy  (grp_rdy),
        .grp_base (grp_base)
    );

    for (genvar k = 0; k < SLOTS; k++) begin : g_line
        vs_linemem #(.DEPTH(LINE_PIX), .W(8)) u_mem (
            .clk  (clk),
            .we   (wr_en && (wr_slot == 2'(k))),
            .waddr(wr_col),
            .wdata(src_pix),
            .raddr(rd_col),
            .rdata(rd[k])
        );
    end

    vs_seq #(
        .LINE_PIX(LINE_PIX),
        .H_BLANK (H_BLANK),
        .HS_W    (HS_W),
        .GROUPS  (GROUPS),
        .VS_LINES(VS_LINES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .grp_rdy (grp_rdy),
        .grp_base(grp_base),
        .skip_en (skip_en),
        .col     (rd_col),
        .base    (base),
        .line_j  (line_j),
        .raw_de  (raw_de),
        .raw_hs  (raw_hs),
        .raw_vs  (raw_vs)
    );

    // Hold the group base and line index alongside the memory read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= 2'd0;
            j_q    <= 3'd0;
        end else begin
            base_q <= base;
            j_q    <= line_j;
        end
    end

    // Route the group's source lines to the four mixer operands.
    for (genvar t = 0; t < 4; t++) begin : g_tap
        always_comb op[t] = rd[base_q + tap_src(mode_blend, j_q, 2'(t))];
    end

    vs_mix4 u_mix (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (op[0]),
        .b    (op[1]),
        .c    (op[2]),
        .d    (op[3]),
        .mix  (mix)
    );

    // Delay enable and syncs to line up with the mixed pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_d <= '0;
            hs_d <= '0;
            vs_d <= '0;
        end else begin
            de_d <= {de_d[PIPE-2:0], raw_de};
            hs_d <= {hs_d[PIPE-2:0], raw_hs};
            vs_d <= {vs_d[PIPE-2:0], raw_vs};
        end
    end

    // Drive the panel outputs, with the colour blanked outside data enable.
    always_comb begin
        out_de  = de_d[PIPE-1];
        out_hs  = hs_d[PIPE-1];
        out_vs  = vs_d[PIPE-1];
        out_pix = out_de ? mix : '0;
    end

endmodule

// File: rtl/vscale_3to5_chk.sv
// Module: checker for the scaler's output rules, attached to the top by bind.
// It counts pulse widths and checks exclusivity and the rounding range.
module vscale_3to5_chk #(
    parameter int LINE_PIX = 256,
    parameter int HS_W     = 8,
    localparam int CW      = $clog2(LINE_PIX + HS_W + 2) + 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [14:0] out_pix,
    input logic        out_de,
    input logic        out_hs,
    input logic        out_vs
);

    logic [CW-1:0] de_run;
    logic [CW-1:0] hs_run;

    // Count the length of the current enable and sync pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_run <= '0;
            hs_run <= '0;
        end else begin
            de_run <= out_de ? de_run + CW'(1) : '0;
            hs_run <= out_hs ? hs_run + CW'(1) : '0;
        end
    end

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!out_de && !out_hs && !out_vs));

    assert_blank_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_pix == 15'd0));

    assert_round_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_de |-> ((out_pix[4:0] != 5'd0) && (out_pix[4:0] <= 5'd29) &&
                    (out_pix[9:5] != 5'd0) && (out_pix[9:5] <= 5'd29) &&
                    (out_pix[14:10] != 5'd0) && (out_pix[14:10] <= 5'd13)));

    assert_de_hs_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_de && out_hs));

    assert_de_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_de) |-> (de_run == CW'(LINE_PIX)));

    assert_hs_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_hs) |-> (hs_run == CW'(HS_W)));

    assert_vs_no_de_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vs |-> !out_de);

endmodule

bind vscale_3to5 vscale_3to5_chk #(.LINE_PIX(LINE_PIX), .HS_W(HS_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .out_pix(out_pix),
    .out_de (out_de),
    .out_hs (out_hs),
    .out_vs (out_vs)
);

// File: tb/vscale_3to5_test.sv
// Bench: directed frames with constant-colour source lines; each task checks
// its own results against sums computed from the requirements.
module vscale_3to5_test;

    localparam int LP   = 8;
    localparam int HB   = 8;
    localparam int HSW  = 3;
    localparam int SL   = 6;
    localparam int VSL  = 2;
    localparam int HT   = LP + HB;
    localparam int OUTL = SL * 5 / 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_valid = 1'b0;
    logic        src_sof = 1'b0;
    logic [7:0]  src_pix = 8'd0;
    logic        mode_blend = 1'b1;
    logic        skip_en = 1'b0;
    logic [14:0] out_pix;
    logic        out_de;
    logic        out_hs;
    logic        out_vs;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0]  cols [SL];
    logic [14:0] line_val [32];
    int n_de_lines, n_de_cyc, n_hs, n_vs_hs, mism;
    logic pde = 1'b0;
    logic phs = 1'b0;

    always #2 clk = ~clk;

    vscale_3to5 #(
        .LINE_PIX(LP), .H_BLANK(HB), .HS_W(HSW), .SRC_LINES(SL), .VS_LINES(VSL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_sof(src_sof),
        .src_pix(src_pix), .mode_blend(mode_blend), .skip_en(skip_en),
        .out_pix(out_pix), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
    );

    // Output monitor, sampling between clock edges.
    always @(negedge clk) begin
        if (out_de && !pde) begin
            if (n_de_lines < 32) line_val[n_de_lines] = out_pix;
            n_de_lines++;
        end else if (out_de && n_de_lines > 0 && n_de_lines <= 32 &&
                     out_pix != line_val[n_de_lines-1]) begin
            mism++;
        end
        if (out_de) n_de_cyc++;
        if (out_hs && !phs) begin
            n_hs++;
            if (out_vs) n_vs_hs++;
        end
        pde = out_de;
        phs = out_hs;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [14:0] expv(input logic [7:0] c0, input logic [7:0] c1,
                                         input logic [7:0] c2, input int j, input bit blend);
        int sel [4];
        logic [7:0] p;
        int r, g, b;
        for (int t = 0; t < 4; t++) begin
            if (blend) begin
                case (j)
                    0: sel[t] = 0;
                    1: sel[t] = (t == 3) ? 1 : 0;
                    2: sel[t] = 1;
                    3: sel[t] = (t >= 2) ? 2 : 1;
                    default: sel[t] = 2;
                endcase
            end else begin
                sel[t] = (j == 0) ? 0 : (j <= 2) ? 1 : 2;
            end
        end
        r = 1; g = 1; b = 1;
        for (int t = 0; t < 4; t++) begin
            p = (sel[t] == 0) ? c0 : (sel[t] == 1) ? c1 : c2;
            r += int'(p[2:0]);
            g += int'(p[5:3]);
            b += int'(p[7:6]);
        end
        return {5'(b), 5'(g), 5'(r)};
    endfunction

    task automatic clear_mon();
        n_de_lines = 0; n_de_cyc = 0; n_hs = 0; n_vs_hs = 0; mism = 0;
    endtask

    // Feed one frame, spacing source lines three output lines apart.
    task automatic feed_frame();
        for (int l = 0; l < SL; l++) begin
            for (int p = 0; p < LP; p++) begin
                @(negedge clk);
                src_valid = 1'b1;
                src_sof = (l == 0 && p == 0);
                src_pix = cols[l];
            end
            @(negedge clk);
            src_valid = 1'b0;
            src_sof = 1'b0;
            repeat (3 * HT - LP - 1) @(negedge clk);
            if (l == 1) chk("R4 no output before third line", n_de_lines, 0);
        end
        repeat (200) @(negedge clk);
    endtask

    task automatic check_lines(input bit blend, input bit skip, input string req);
        int k;
        k = 0;
        for (int s = 0; s < OUTL; s++) begin
            if (!(skip && (s % 6 == 5))) begin
                chk(req, int'(line_val[k]),
                    int'(expv(cols[(s/5)*3], cols[(s/5)*3+1], cols[(s/5)*3+2], s % 5, blend)));
                k++;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 de in reset", int'(out_de), 0);
        chk("R8 hs in reset", int'(out_hs), 0);
        chk("R8 vs in reset", int'(out_vs), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 de after reset", int'(out_de), 0);
        chk("R1 pixel blank after reset", int'(out_pix), 0);
    endtask

    task automatic t_blend(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2,
                           input logic [7:0] c3, input logic [7:0] c4, input logic [7:0] c5);
        cols[0] = c0; cols[1] = c1; cols[2] = c2; cols[3] = c3; cols[4] = c4; cols[5] = c5;
        mode_blend = 1'b1; skip_en = 1'b0;
        clear_mon();
        feed_frame();
        chk("R6 enabled lines", n_de_lines, OUTL);
        chk("R6 hsync pulses", n_hs, OUTL + VSL);
        chk("R6 vsync lines", n_vs_hs, VSL);
        chk("R5 enabled clocks", n_de_cyc, OUTL * LP);
        chk("R5 constant within line", mism, 0);
        check_lines(1'b1, 1'b0, "R2 blend line value");
    endtask

    task automatic t_format();
        for (int l = 0; l < SL; l++) cols[l] = 8'h07;
        mode_blend = 1'b1; skip_en = 1'b0;
        clear_mon();
        feed_frame();
        chk("R1 red-only field placement", int'(line_val[0]), (1 << 10) | (1 << 5) | 29);
        for (int l = 0; l < SL; l++) cols[l] = 8'hC0;
        clear_mon();
        feed_frame();
        chk("R1 blue-only field placement", int'(line_val[0]), (13 << 10) | (1 << 5) | 1);
    endtask

    task automatic t_repeat();
        cols[0] = 8'h41; cols[1] = 8'h8A; cols[2] = 8'hD3;
        cols[3] = 8'h1C; cols[4] = 8'h65; cols[5] = 8'hAE;
        mode_blend = 1'b0; skip_en = 1'b0;
        clear_mon();
        feed_frame();
        chk("R3 enabled lines", n_de_lines, OUTL);
        check_lines(1'b0, 1'b0, "R3 repeat line value");
    endtask

    task automatic t_skip();
        cols[0] = 8'h09; cols[1] = 8'h52; cols[2] = 8'h9B;
        cols[3] = 8'hE4; cols[4] = 8'h2D; cols[5] = 8'h76;
        mode_blend = 1'b1; skip_en = 1'b1;
        clear_mon();
        feed_frame();
        chk("R7 enabled lines with skip", n_de_lines, OUTL - OUTL / 6);
        chk("R7 hsync pulses with skip", n_hs, OUTL + VSL);
        chk("R7 vsync lines with skip", n_vs_hs, VSL);
        check_lines(1'b1, 1'b1, "R7 line value after skip");
        skip_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        repeat (5) @(negedge clk);
        t_blend(8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF);
        t_blend(8'h12, 8'h9B, 8'h47, 8'hE5, 8'h3C, 8'h76);
        t_format();
        t_repeat();
        t_skip();
        t_blend(8'hA5, 8'h5A, 8'hF0, 8'h0F, 8'h33, 8'hCC);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule